// File: doc/BRIEF.md
# Sampling converter serial readout port

This block is the digital back end of a 12-bit sampling converter. A conversion-start strobe begins a conversion on its rising edge. After a fixed conversion time, counted in system clocks, the converter delivers a 12-bit result. The block then places that result in an output register. An external host clocks the register out over a two-wire serial link. The host supplies the serial clock, and the block drives a serial data line that it can release to high impedance.

Every read is a 16-bit frame: four zero bits, then the result with its most significant bit first. The serial clock and the strobe are asynchronous to the system clock. Each passes through a synchroniser, and edges are detected on the synchronised copies. The block allows at least four system clocks per serial clock phase. A falling strobe edge puts the bit counter back to the start of a frame, but only while the serial clock is low. A new result does not overwrite the output register during a read. It waits until that read ends or until the next falling strobe edge, whichever comes first.

The frame state machine has four states. FR_IDLE (released, counter zero) goes to FR_READ on a serial clock rise. FR_READ (first frame, driven) goes to FR_DONE on the falling edge that ends bit 16. FR_DONE (released) goes to FR_OVER on a further rise. FR_OVER (driven, counter wraps from 16 to 1) stays there. Any state returns to FR_IDLE on a falling strobe edge seen while the serial clock is low. The update state machine has two states. UP_IDLE goes to UP_HOLD when a result arrives during a read. UP_HOLD goes back to UP_IDLE when the read completes or the strobe falls, and the held result enters the output register at that moment.

Top module: `adc_serial_port`

## Requirements
- R1: A result offered on `result_i` enters the output register a fixed number of system clocks (SYS_CLK_MHZ × CONV_TIME_NS / 1000, about 600 by default) after the strobe rises, provided no read is in progress.
- R2: A frame carries 16 bits. Bits 1 to 4 are 0, and bits 5 to 16 are the output register, bit 11 first. Serial bit n is launched after the n-th rising serial clock edge and holds until the next rising edge.
- R3: `sdata_oe_o` goes high with the first rising serial clock edge of a frame. It stays high through bit 16 and goes low after the 16th falling edge.
- R4: A rising serial clock edge after a completed frame starts the frame again from bit 1, using the current output register. After that, `sdata_oe_o` stays high even when the serial clock stops.
- R5: A falling strobe edge while the serial clock is low resets the bit counter. `sdata_oe_o` goes low, and the next rising edge launches bit 1.
- R6: A falling strobe edge while the serial clock is high leaves the bit counter alone, and the frame goes on without a break.
- R7: A result that arrives while a read is in progress does not change the frame being read. It enters the output register when that read completes.
- R8: If a read is still unfinished at the next falling strobe edge, the held result enters the output register at that edge.
- R9: The serial clock may stay low for any number of cycles within a frame, and the frame resumes at the next bit.
- R10: After reset `sdata_oe_o` and `sdata_o` are 0 and the output register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_strobe_i | input | 1 | Conversion-start strobe (asynchronous). The rising edge starts a conversion and the falling edge resynchronises the frame |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| result_i | input | RES_W | Conversion result from the behavioural converter, taken when the conversion time ends |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Output enable for the serial data pad. 0 means high impedance |

## Verification
The hardest situation to reach is a conversion that ends in the middle of a read. Two cases follow from it: the read then either completes, or is cut off by the next strobe fall. To reach it, the bench starts a read directly after the strobe pulse and stops the serial clock low partway through. It waits past the conversion time, then either finishes the frame or pulses the strobe. It then reads the next frame to see which value the output register holds. Random results and random pause positions drive both orders many times. Directed cases cover the strobe falling while the serial clock is high and extra clocks after bit 16.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
    typedef enum logic [1:0] {
        FR_IDLE,
        FR_READ,
        FR_DONE,
        FR_OVER
    } frame_state_e;

    typedef enum logic {
        UP_IDLE,
        UP_HOLD
    } update_state_e;
endpackage

// File: rtl/adcs_sync.sv
module adcs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic prev_o
);
    // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_i};
    end

    assign level_o = chain_q[STAGES-1];
    assign prev_o  = chain_q[STAGES];
endmodule

// File: rtl/adcs_conv_timer.sv
module adcs_conv_timer #(
    parameter int CYCLES = 600,
    localparam int TW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    logic          busy_q;
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                busy_q <= 1'b1;
                cnt_q  <= TW'(CYCLES - 1);
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    // R1: completion is a single-cycle event
    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/adcs_frame_ctrl.sv
module adcs_frame_ctrl import adcs_pkg::*; #(
    parameter int FRAME_LEN = 16,
    localparam int CNT_W = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise_i,
    input  logic             sclk_fall_i,
    input  logic             sclk_lvl_i,
    input  logic             strb_fall_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             drive_o,
    output logic             reading_o,
    output logic             read_done_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             resync;

    assign resync = strb_fall_i && !sclk_lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (resync) begin
            state_d = FR_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FR_IDLE: if (sclk_rise_i) begin
                    state_d = FR_READ;
                    cnt_d   = ONE;
                end
                FR_READ: begin
                    if (sclk_rise_i && cnt_q != LAST) cnt_d = cnt_q + ONE;
                    else if (sclk_fall_i && cnt_q == LAST) state_d = FR_DONE;
                end
                FR_DONE: if (sclk_rise_i) begin
                    state_d = FR_OVER;
                    cnt_d   = ONE;
                end
                FR_OVER: if (sclk_rise_i) begin
                    cnt_d = (cnt_q == LAST) ? ONE : cnt_q + ONE;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cnt_o       = cnt_q;
        drive_o     = (state_q == FR_READ) || (state_q == FR_OVER);
        reading_o   = (state_q == FR_READ);
        read_done_o = (state_q == FR_READ) && sclk_fall_i && (cnt_q == LAST) && !resync;
    end

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    a_r5_resync_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_fall_i && !sclk_lvl_i) |=> (cnt_q == '0 && !drive_o));

    a_r6_high_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_fall_i && sclk_lvl_i && !sclk_rise_i) |=> ($stable(cnt_q) && $stable(state_q)));

    a_r3_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (reading_o && sclk_fall_i && cnt_q == LAST && !strb_fall_i) |=> !drive_o);

    a_r4_overrun_stays_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_OVER && !(strb_fall_i && !sclk_lvl_i)) |=> drive_o);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port import adcs_pkg::*; #(
    parameter int SYS_CLK_MHZ  = 100,
    parameter int CONV_TIME_NS = 6000,
    parameter int RES_W        = 12,
    parameter int LEAD_W       = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_strobe_i,
    input  logic             sclk_i,
    input  logic [RES_W-1:0] result_i,
    output logic             sdata_o,
    output logic             sdata_oe_o
);
    localparam int FRAME_LEN   = RES_W + LEAD_W;
    localparam int CONV_CYCLES = SYS_CLK_MHZ * CONV_TIME_NS / 1000;
    localparam int CNT_W       = $clog2(FRAME_LEN + 1);
    localparam int IDX_W       = $clog2(FRAME_LEN);

    logic strb_lvl, strb_prev, sclk_lvl, sclk_prev;
    logic strb_rise, strb_fall, sclk_rise, sclk_fall;
    logic conv_done;
    logic [CNT_W-1:0] bit_cnt;
    logic drive, reading, read_done;

    adcs_sync #(.STAGES(SYNC_STAGES)) u_strb_sync (
        .clk(clk), .rst_n(rst_n), .async_i(conv_strobe_i),
        .level_o(strb_lvl), .prev_o(strb_prev));

    adcs_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sclk_i),
        .level_o(sclk_lvl), .prev_o(sclk_prev));

    assign strb_rise = strb_lvl && !strb_prev;
    assign strb_fall = !strb_lvl && strb_prev;
    assign sclk_rise = sclk_lvl && !sclk_prev;
    assign sclk_fall = !sclk_lvl && sclk_prev;

    adcs_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(strb_rise), .done_o(conv_done));

    adcs_frame_ctrl #(.FRAME_LEN(FRAME_LEN)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
        .sclk_lvl_i(sclk_lvl), .strb_fall_i(strb_fall),
        .cnt_o(bit_cnt), .drive_o(drive),
        .reading_o(reading), .read_done_o(read_done));

    // output register update machine
    update_state_e    up_q, up_d;
    logic [RES_W-1:0] out_q, out_d, pend_q, pend_d;
    logic             release_hold;

    assign release_hold = read_done || strb_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q   <= UP_IDLE;
            out_q  <= '0;
            pend_q <= '0;
        end else begin
            up_q   <= up_d;
            out_q  <= out_d;
            pend_q <= pend_d;
        end
    end

    always_comb begin
        up_d   = up_q;
        out_d  = out_q;
        pend_d = pend_q;
        unique case (up_q)
            UP_IDLE: if (conv_done) begin
                if (reading && !release_hold) begin
                    pend_d = result_i;
                    up_d   = UP_HOLD;
                end else begin
                    out_d = result_i;
                end
            end
            UP_HOLD: begin
                if (release_hold) begin
                    out_d = conv_done ? result_i : pend_q;
                    up_d  = UP_IDLE;
                end else if (conv_done) begin
                    pend_d = result_i;
                end
            end
            default: ;
        endcase
    end

    // serial output
    logic [FRAME_LEN-1:0] frame_w;
    assign frame_w = {{LEAD_W{1'b0}}, out_q};

    always_comb begin
        sdata_oe_o = drive;
        sdata_o    = 1'b0;
        if (drive && bit_cnt != '0)
            sdata_o = frame_w[IDX_W'(FRAME_LEN - int'(bit_cnt))];
    end

    a_r7_defer_keeps_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && !read_done && !strb_fall) |=> $stable(out_q));

    a_r8_strobe_releases_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q == UP_HOLD && strb_fall) |=> (up_q == UP_IDLE));

    a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive) |-> (!sdata_o));
endmodule

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
    localparam int HALF = 5;
    localparam int CONV_WAIT = 700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic        sclk = 1'b0;
    logic [11:0] result = '0;
    logic        sdata, sdata_oe;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;
    logic [15:0] acc;
    bit          oe_all;
    logic [11:0] cur_out;

    always #5 clk = ~clk;

    adc_serial_port uut (
        .clk(clk), .rst_n(rst_n), .conv_strobe_i(strobe), .sclk_i(sclk),
        .result_i(result), .sdata_o(sdata), .sdata_oe_o(sdata_oe));

    function automatic logic [15:0] exp_frame(input logic [11:0] r);
        return {4'b0000, r};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic one_bit();
        sclk = 1'b1;
        wait_cyc(HALF);
        acc = {acc[14:0], sdata};
        if (!sdata_oe) oe_all = 1'b0;
        sclk = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic bits(input int n);
        for (int i = 0; i < n; i++) one_bit();
    endtask

    task automatic begin_frame();
        acc = '0;
        oe_all = 1'b1;
    endtask

    task automatic strobe_pulse();
        strobe = 1'b1;
        wait_cyc(6);
        strobe = 1'b0;
        wait_cyc(6);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);
        // R10: reset state
        check(!sdata_oe && !sdata, "R10 reset outputs", {14'b0, sdata_oe, sdata}, 16'h0000);
        begin_frame();
        bits(16);
        check(acc == 16'h0000, "R10 reset register", acc, 16'h0000);
        strobe_pulse();
        wait_cyc(CONV_WAIT);

        // R1 R2 R3: plain conversion then read
        result = 12'hABC;
        strobe_pulse();
        wait_cyc(CONV_WAIT);
        begin_frame();
        bits(16);
        check(acc == exp_frame(12'hABC), "R1 R2 frame after conversion", acc, exp_frame(12'hABC));
        check(oe_all, "R3 driven during frame", {15'b0, oe_all}, 16'h0001);
        check(!sdata_oe, "R3 released after 16th fall", {15'b0, sdata_oe}, 16'h0000);
        cur_out = 12'hABC;

        // R4: over-clocking restarts and stays driven
        begin_frame();
        bits(1);
        wait_cyc(50);
        check(sdata_oe, "R4 driven after clocks stop", {15'b0, sdata_oe}, 16'h0001);
        bits(15);
        check(acc == exp_frame(cur_out), "R4 restarted frame", acc, exp_frame(cur_out));
        wait_cyc(30);
        check(sdata_oe, "R4 still driven after second frame", {15'b0, sdata_oe}, 16'h0001);
        strobe_pulse();
        check(!sdata_oe, "R5 resync releases line", {15'b0, sdata_oe}, 16'h0000);
        wait_cyc(CONV_WAIT);

        // R7 R9: conversion ends during a paused read
        result = 12'h5A3;
        strobe_pulse();
        begin_frame();
        bits(8);
        wait_cyc(CONV_WAIT);
        bits(8);
        check(acc == exp_frame(cur_out), "R7 R9 frame keeps old value", acc, exp_frame(cur_out));
        cur_out = 12'h5A3;
        strobe_pulse();
        begin_frame();
        bits(16);
        check(acc == exp_frame(cur_out), "R7 deferred value loaded", acc, exp_frame(cur_out));
        wait_cyc(CONV_WAIT);

        // R8: unfinished read cut by strobe fall
        result = 12'h3C7;
        strobe_pulse();
        begin_frame();
        bits(8);
        wait_cyc(CONV_WAIT);
        strobe_pulse();
        check(!sdata_oe, "R5 R8 counter reset by strobe", {15'b0, sdata_oe}, 16'h0000);
        cur_out = 12'h3C7;
        begin_frame();
        bits(16);
        check(acc == exp_frame(cur_out), "R8 held value loaded at strobe", acc, exp_frame(cur_out));
        wait_cyc(CONV_WAIT);

        // R6: strobe falls while serial clock is high
        begin_frame();
        bits(6);
        sclk = 1'b1;
        wait_cyc(HALF);
        acc = {acc[14:0], sdata};
        strobe = 1'b1;
        wait_cyc(6);
        strobe = 1'b0;
        wait_cyc(6);
        sclk = 1'b0;
        wait_cyc(HALF);
        bits(9);
        check(acc == exp_frame(cur_out), "R6 frame continues", acc, exp_frame(cur_out));
        wait_cyc(CONV_WAIT);
        strobe_pulse();
        wait_cyc(CONV_WAIT);

        // random mix of normal and deferred reads
        for (int it = 0; it < 24; it++) begin
            logic [11:0] nv;
            int split;
            nv = 12'($urandom);
            split = 1 + int'($urandom % 15);
            result = nv;
            strobe_pulse();
            begin_frame();
            if ($urandom % 2 == 0) begin
                wait_cyc(CONV_WAIT);
                bits(split);
                wait_cyc(int'($urandom % 40));
                bits(16 - split);
                cur_out = nv;
                check(acc == exp_frame(cur_out), "R1 R9 random read", acc, exp_frame(cur_out));
            end else begin
                bits(split);
                wait_cyc(CONV_WAIT);
                bits(16 - split);
                check(acc == exp_frame(cur_out), "R7 random deferred", acc, exp_frame(cur_out));
                cur_out = nv;
            end
            check(!sdata_oe, "R3 random release", {15'b0, sdata_oe}, 16'h0000);
        end
        finish_run();
    end
endmodule